// File: doc/BRIEF.md
# Four-Lane Codeword Distributor with Departure Timestamping

The block accepts one codeword per clock from a single stream and spreads consecutive codewords over four lanes in rotating order. Codewords wait in a buffer until the group is complete, and then all four lanes are presented in the same cycle. Because the group leaves together, the first codeword of a group waits longest and the last codeword does not wait.

One codeword in a group may carry a marker meaning "this holds the timestamp point". For that codeword the block reports the lane that carried it and a departure timestamp. The timestamp is based on the value of the time input at the moment the codeword was accepted. A mode input selects how the buffer delay is added. In per-lane mode, the real number of cycles the codeword waited is converted to nanoseconds and added. In constant mode, one fixed offset is added for every lane. The receive side waits in the opposite lane order, so in constant mode the differences between lanes cancel over the link.

Top module: `lane_dist_ts`

## Requirements
- R1: While `rst_ni` is low and after it is released, `lane_valid_o`, `ts_valid_o`, `lanes_o`, `ts_o` and `ts_lane_o` are zero. Reset also returns the lane position to 0, so the first codeword accepted after reset always goes to lane 0, even if reset arrives in the middle of a group.
- R2: Accepted codewords (`cw_valid_i` high) fill lanes 0, 1, 2, 3 in order. Lane k occupies bits [k*CW_W +: CW_W] of `lanes_o`.
- R3: The codeword for lane 3 is accepted at a clock edge. At that same edge all four lanes are loaded together, and `lane_valid_o` is high for exactly the following cycle. Cycles with `cw_valid_i` low do not advance the lane position and produce no launch.
- R4: `lanes_o` holds its value between launches.
- R5: Suppose the group contains a codeword accepted with `cw_tsp_i` high. Then `ts_valid_o` is high in the same cycle as that group's `lane_valid_o`, and `ts_lane_o` gives that codeword's lane (0 to 3).
- R6: With `mode_const_i` = 0 at the launch edge, `ts_o` = T + W*CLK_NS modulo 2^TS_W. T is `time_i` at the accepting edge of the flagged codeword. W is the number of clock edges from that edge to the launch edge. With no gaps, W = 3 - lane.
- R7: With `mode_const_i` = 1 at the launch edge, `ts_o` = T + CONST_OFS_NS for every lane. The default is half the span of the longest wait, rounded half up: ((NUM_LANES-1)*CLK_NS+1)/2, which is 6 for CLK_NS = 4.
- R8: If several codewords in one group are flagged, only the first one is reported.
- R9: A group with no flagged codeword leaves `ts_valid_o` low, and `ts_o` and `ts_lane_o` keep their previous values.
- R10: Idle cycles between the flagged codeword and the launch add to W in per-lane mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cw_valid_i | input | 1 | Codeword present this cycle |
| cw_data_i | input | CW_W | Codeword |
| cw_tsp_i | input | 1 | Codeword holds the timestamp point |
| time_i | input | TS_W | Local time in nanoseconds |
| mode_const_i | input | 1 | 0: per-lane wait added, 1: constant offset |
| lane_valid_o | output | 1 | All lanes launched this cycle |
| lanes_o | output | NUM_LANES*CW_W | Lane words, lane k at bits [k*CW_W +: CW_W] |
| ts_valid_o | output | 1 | Departure timestamp valid |
| ts_lane_o | output | LANE_W | Lane of the timestamp point |
| ts_o | output | TS_W | Departure timestamp |

## Verification
The assertions assume that `cw_valid_i` is a plain per-cycle strobe and that reset is asserted at time zero. They also assume that a launch can only follow an accepted codeword, which makes back-to-back launches impossible for four lanes. The stimulus drives every input on the falling edge and holds `mode_const_i` steady for the whole of a group. It inserts idle cycles only between codewords of a group. It flags more than one codeword in a group only in the scenario that checks which flag is reported.

// File: rtl/lane_dist_ts_pkg.sv
package lane_dist_ts_pkg;
  typedef enum logic {
    TS_MODE_LANE  = 1'b0,
    TS_MODE_CONST = 1'b1
  } ts_mode_e;
endpackage

// File: rtl/lane_dist_seq.sv
module lane_dist_seq #(
  parameter int NUM_LANES = 4,
  localparam int LANE_W = $clog2(NUM_LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  output logic [LANE_W-1:0] pos_o,
  output logic              accept_o,
  output logic              launch_o
);
  localparam logic [LANE_W-1:0] LAST = LANE_W'(NUM_LANES - 1);
  logic [LANE_W-1:0] pos_q;

  assign accept_o = valid_i;
  assign launch_o = valid_i && (pos_q == LAST);
  assign pos_o    = pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pos_q <= '0;
    else if (launch_o) pos_q <= '0;
    else if (accept_o) pos_q <= pos_q + 1'b1;
  end
endmodule

// File: rtl/lane_dist_buf.sv
module lane_dist_buf #(
  parameter int NUM_LANES = 4,
  parameter int CW_W      = 66,
  localparam int LANE_W = $clog2(NUM_LANES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      accept_i,
  input  logic                      launch_i,
  input  logic [LANE_W-1:0]         pos_i,
  input  logic [CW_W-1:0]           data_i,
  output logic [NUM_LANES*CW_W-1:0] lanes_o,
  output logic                      lane_valid_o
);
  logic [NUM_LANES*CW_W-1:0] lanes_q;
  logic                      valid_q;

  for (genvar k = 0; k < NUM_LANES; k++) begin : g_lane
    if (k < NUM_LANES - 1) begin : g_wait
      // waiting slot: held until the last lane arrives
      logic [CW_W-1:0] slot_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) slot_q <= '0;
        else if (accept_i && pos_i == LANE_W'(k)) slot_q <= data_i;
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       lanes_q[k*CW_W +: CW_W] <= '0;
        else if (launch_i) lanes_q[k*CW_W +: CW_W] <= slot_q;
      end
    end else begin : g_last
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)       lanes_q[k*CW_W +: CW_W] <= '0;
        else if (launch_i) lanes_q[k*CW_W +: CW_W] <= data_i;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= launch_i;
  end

  assign lanes_o      = lanes_q;
  assign lane_valid_o = valid_q;
endmodule

// File: rtl/lane_dist_stamp.sv
module lane_dist_stamp
  import lane_dist_ts_pkg::*;
#(
  parameter int NUM_LANES    = 4,
  parameter int TS_W         = 32,
  parameter int WAIT_W       = 16,
  parameter int CLK_NS       = 4,
  parameter int CONST_OFS_NS = 6,
  localparam int LANE_W = $clog2(NUM_LANES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              accept_i,
  input  logic              launch_i,
  input  logic [LANE_W-1:0] pos_i,
  input  logic              tsp_i,
  input  logic [TS_W-1:0]   time_i,
  input  ts_mode_e          mode_i,
  output logic              ts_valid_o,
  output logic [LANE_W-1:0] ts_lane_o,
  output logic [TS_W-1:0]   ts_o
);
  logic              pend_q;
  logic [TS_W-1:0]   base_q;
  logic [LANE_W-1:0] lane_q;
  logic [WAIT_W-1:0] wait_q;

  logic              emit;
  logic [TS_W-1:0]   emit_base, emit_wait, emit_ts;
  logic [LANE_W-1:0] emit_lane;

  always_comb begin
    emit      = launch_i && (pend_q || tsp_i);
    emit_base = pend_q ? base_q : time_i;
    emit_lane = pend_q ? lane_q : pos_i;
    // the launch edge itself counts as one more cycle of waiting
    emit_wait = pend_q ? TS_W'(wait_q) + 1'b1 : '0;
    if (mode_i == TS_MODE_CONST) emit_ts = emit_base + TS_W'(CONST_OFS_NS);
    else                         emit_ts = emit_base + emit_wait * TS_W'(CLK_NS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= 1'b0;
      base_q <= '0;
      lane_q <= '0;
      wait_q <= '0;
    end else if (launch_i) begin
      pend_q <= 1'b0;
    end else begin
      if (pend_q && wait_q != '1) wait_q <= wait_q + 1'b1;
      if (accept_i && tsp_i && !pend_q) begin
        pend_q <= 1'b1;
        base_q <= time_i;
        lane_q <= pos_i;
        wait_q <= '0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ts_valid_o <= 1'b0;
      ts_lane_o  <= '0;
      ts_o       <= '0;
    end else begin
      ts_valid_o <= emit;
      if (emit) begin
        ts_lane_o <= emit_lane;
        ts_o      <= emit_ts;
      end
    end
  end
endmodule

// File: rtl/lane_dist_ts.sv
module lane_dist_ts
  import lane_dist_ts_pkg::*;
#(
  parameter int NUM_LANES    = 4,
  parameter int CW_W         = 66,
  parameter int TS_W         = 32,
  parameter int WAIT_W       = 16,
  parameter int CLK_NS       = 4,
  parameter int CONST_OFS_NS = ((NUM_LANES - 1) * CLK_NS + 1) / 2,
  localparam int LANE_W = $clog2(NUM_LANES)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      cw_valid_i,
  input  logic [CW_W-1:0]           cw_data_i,
  input  logic                      cw_tsp_i,
  input  logic [TS_W-1:0]           time_i,
  input  logic                      mode_const_i,
  output logic                      lane_valid_o,
  output logic [NUM_LANES*CW_W-1:0] lanes_o,
  output logic                      ts_valid_o,
  output logic [LANE_W-1:0]         ts_lane_o,
  output logic [TS_W-1:0]           ts_o
);
  logic [LANE_W-1:0] pos;
  logic              accept, launch;
  ts_mode_e          mode;

  assign mode = mode_const_i ? TS_MODE_CONST : TS_MODE_LANE;

  lane_dist_seq #(.NUM_LANES(NUM_LANES)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .valid_i  (cw_valid_i),
    .pos_o    (pos),
    .accept_o (accept),
    .launch_o (launch)
  );

  lane_dist_buf #(.NUM_LANES(NUM_LANES), .CW_W(CW_W)) u_buf (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .accept_i     (accept),
    .launch_i     (launch),
    .pos_i        (pos),
    .data_i       (cw_data_i),
    .lanes_o      (lanes_o),
    .lane_valid_o (lane_valid_o)
  );

  lane_dist_stamp #(
    .NUM_LANES(NUM_LANES), .TS_W(TS_W), .WAIT_W(WAIT_W),
    .CLK_NS(CLK_NS), .CONST_OFS_NS(CONST_OFS_NS)
  ) u_stamp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .accept_i   (accept),
    .launch_i   (launch),
    .pos_i      (pos),
    .tsp_i      (cw_tsp_i),
    .time_i     (time_i),
    .mode_i     (mode),
    .ts_valid_o (ts_valid_o),
    .ts_lane_o  (ts_lane_o),
    .ts_o       (ts_o)
  );
endmodule

// File: rtl/lane_dist_ts_chk.sv
module lane_dist_ts_chk #(
  parameter int NUM_LANES = 4,
  parameter int CW_W      = 66,
  parameter int TS_W      = 32,
  localparam int LANE_W = $clog2(NUM_LANES)
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      cw_valid_i,
  input logic                      lane_valid_o,
  input logic [NUM_LANES*CW_W-1:0] lanes_o,
  input logic                      ts_valid_o,
  input logic [LANE_W-1:0]         ts_lane_o,
  input logic [TS_W-1:0]           ts_o
);
  assert_launch_after_accept_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_valid_o |-> $past(cw_valid_i));

  assert_launch_single_pulse_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lane_valid_o |=> !lane_valid_o);

  assert_lanes_held_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lane_valid_o |-> $stable(lanes_o));

  assert_ts_with_launch_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ts_valid_o |-> lane_valid_o);

  assert_ts_held_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ts_valid_o |-> ($stable(ts_o) && $stable(ts_lane_o)));
endmodule

bind lane_dist_ts lane_dist_ts_chk #(
  .NUM_LANES(NUM_LANES), .CW_W(CW_W), .TS_W(TS_W)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .cw_valid_i   (cw_valid_i),
  .lane_valid_o (lane_valid_o),
  .lanes_o      (lanes_o),
  .ts_valid_o   (ts_valid_o),
  .ts_lane_o    (ts_lane_o),
  .ts_o         (ts_o)
);

// File: tb/lane_dist_ts_test.sv
module lane_dist_ts_test;
  localparam int CLK_PERIOD = 10;
  localparam int NL   = 4;
  localparam int CW_W = 66;
  localparam int TS_W = 32;
  localparam int CLK_NS = 4;
  localparam int OFS_NS = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cw_valid = 1'b0;
  logic [CW_W-1:0] cw_data = '0;
  logic cw_tsp = 1'b0;
  logic [TS_W-1:0] time_q;
  logic mode_const = 1'b0;
  logic lane_valid, ts_valid;
  logic [NL*CW_W-1:0] lanes;
  logic [1:0] ts_lane;
  logic [TS_W-1:0] ts;

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;
  logic [TS_W-1:0] exp_ts = '0;
  logic [1:0] exp_lane = '0;

  lane_dist_ts uut (
    .clk_i(clk), .rst_ni(rst_n), .cw_valid_i(cw_valid), .cw_data_i(cw_data),
    .cw_tsp_i(cw_tsp), .time_i(time_q), .mode_const_i(mode_const),
    .lane_valid_o(lane_valid), .lanes_o(lanes), .ts_valid_o(ts_valid),
    .ts_lane_o(ts_lane), .ts_o(ts)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) time_q <= 32'd1000;
    else        time_q <= time_q + TS_W'(CLK_NS);
  end

  task automatic chk(input string req, input string what, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // One group of four codewords; fa/fb flagged positions (-1 none), idle gap after word 1.
  task automatic run_group(input string req, input int fa, input int fb, input int gap,
                           input logic mode, input logic [CW_W-1:0] base);
    logic [TS_W-1:0] t_flag = '0;
    int c_flag = 0, lane_f = -1;
    mode_const = mode;
    for (int k = 0; k < NL; k++) begin
      @(negedge clk);
      cw_valid = 1'b1;
      cw_data  = base + CW_W'(k);
      cw_tsp   = (k == fa) || (k == fb);
      if (cw_tsp && lane_f < 0) begin
        lane_f = k; t_flag = time_q; c_flag = cyc;
      end
      if (k == NL - 1 && lane_f >= 0) begin
        exp_lane = 2'(lane_f);
        exp_ts = mode ? t_flag + TS_W'(OFS_NS)
                      : t_flag + TS_W'((cyc - c_flag) * CLK_NS);
      end
      if (k == 1) begin
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          cw_valid = 1'b0; cw_tsp = 1'b0;
          chk("R3", "no launch during idle", {127'd0, lane_valid}, 128'd0);
        end
      end
    end
    @(negedge clk);
    cw_valid = 1'b0; cw_tsp = 1'b0;
    chk("R3", "lane_valid at launch", {127'd0, lane_valid}, 128'd1);
    for (int k = 0; k < NL; k++)
      chk("R2", $sformatf("lane %0d word", k), 128'(lanes[k*CW_W +: CW_W]), 128'(base + CW_W'(k)));
    chk(req, "ts_valid", {127'd0, ts_valid}, {127'd0, lane_f >= 0});
    chk(req, "ts", 128'(ts), 128'(exp_ts));
    chk(req, "ts_lane", 128'(ts_lane), 128'(exp_lane));
    @(negedge clk);
    chk("R3", "lane_valid one cycle", {127'd0, lane_valid}, 128'd0);
    chk("R4", "lanes held", 128'(lanes[0 +: CW_W]), 128'(base));
  endtask

  task automatic test_reset();
    repeat (3) @(negedge clk);
    chk("R1", "lane_valid", {127'd0, lane_valid}, 128'd0);
    chk("R1", "ts_valid", {127'd0, ts_valid}, 128'd0);
    chk("R1", "lanes", 128'(lanes[127:0]), 128'd0);
    chk("R1", "ts", 128'(ts), 128'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "lane_valid after release", {127'd0, lane_valid}, 128'd0);
  endtask

  task automatic test_mid_group_reset();
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      cw_valid = 1'b1; cw_data = 66'h3F0 + CW_W'(k); cw_tsp = 1'b0;
    end
    @(negedge clk);
    cw_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    exp_ts = '0; exp_lane = '0;
    run_group("R1", 3, -1, 0, 1'b0, 66'h2_0000_0000_0000_0500);
  endtask

  initial begin
    test_reset();
    run_group("R6", 0, -1, 0, 1'b0, 66'h100);
    run_group("R6", 1, -1, 0, 1'b0, 66'h110);
    run_group("R6", 2, -1, 0, 1'b0, 66'h120);
    run_group("R6", 3, -1, 0, 1'b0, 66'h130);
    run_group("R7", 0, -1, 0, 1'b1, 66'h140);
    run_group("R7", 3, -1, 0, 1'b1, 66'h150);
    run_group("R5", 2, -1, 0, 1'b1, 66'h160);
    run_group("R9", -1, -1, 0, 1'b0, 66'h170);
    run_group("R8", 1, 2, 0, 1'b0, 66'h180);
    run_group("R10", 0, -1, 3, 1'b0, 66'h190);
    run_group("R7", 1, -1, 2, 1'b1, 66'h1A0);
    test_mid_group_reset();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule